// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

This block produces the vertical timing of one display pipe. It counts scanlines on a one-cycle horizontal line strobe. From that count it drives a vertical blanking flag, a one-cycle frame-start pulse and a one-cycle register-latch strobe. The latch strobe marks the clock edge at which the double-buffered timing settings move from their written (shadow) copy into the copy that governs the counter.

In fixed mode a frame has a programmed total number of lines. The latch point is the first blanking line.

In variable mode, blanking after the active lines is held open until software requests its end. A request can end blanking no earlier than a minimum line, which is derived from the flip line (or from vmin when the flip line is switched off). If no request arrives, blanking is forced to end at the vmax boundary. Once blanking ends, an exit sequence of fixed length follows and the frame wraps to line zero. The latch happens at the first line of that exit sequence.

Software configures the block through a write-only port of seven registers. Horizontal timing, pixel data and deriving the limits from a monitor's range are all handled elsewhere.

Top module: `vrr_vtiming_gen`

## Requirements
- R1: After reset, line_num is 0 and vblank, frame_start and latch_stb are low. The live settings come from the parameters: DEF_VACT active lines, a fixed total of DEF_VTOT lines, and fixed mode selected.
- R2: line_num advances by exactly one per clock on which line_stb is high, and otherwise holds. vblank is high from line vact until the frame wraps.
- R3: In fixed mode a frame lasts VTOT+1 lines. On the strobe that ends the frame, line_num returns to 0 and frame_start is high for one clock.
- R4: In fixed mode, latch_stb pulses for one clock as line_num becomes vact.
- R5: Register writes reach the shadow copy only. The live copy changes only on a latch, so a write made after the latch point of a frame does not change that frame.
- R6: Writes go through cfg_wr, cfg_addr and cfg_wdata. The addresses are: 0 = active line count; 1 = total minus one; 2 = vmin minus one; 3 = vmax minus one; 4 = flip line minus one; 5 = control; 6 = push. In the control register, bit0 turns on variable mode, bit1 turns on the flip line, bit2 turns on the pipeline-fill override, bits[4:3] hold the frame-start delay (0 to 3) and bits[12:5] hold the 8-bit pipeline-fill count. In the push register, bit0 is enable and bit1 is send.
- R7: The exit sequence lasts E = P + D + 1 lines. D is the frame-start delay. P is the pipeline-fill count when the override bit is set and 0 when it is clear. If the exit begins as line_num becomes X, the frame wraps after line X+E-1.
- R8: In variable mode with no push, the exit begins at line (VMAX+1)-E. The frame then lasts VMAX+1 lines and latch_stb pulses at that line.
- R9: The earliest exit line is M = max(vact+1, F-E). F is FLIP+1 when the flip line is on and VMIN+2 when it is off. A push made before M is held until line M.
- R10: A push made while line_num is at or past M and before the vmax boundary starts the exit on the next line strobe.
- R11: A push is accepted only in variable mode, and only when a push write sets both enable and send. An accepted push serves one exit and is then cleared. A push write with only send set has no effect on frame length.
- R12: Writing 0 to control switches the block back to fixed mode at the next latch. After that, frames last VTOT+1 lines and pushes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle pulse per scanline |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 13 | Register write data |
| line_num | output | 12 | Current line within the frame |
| vblank | output | 1 | High during vertical blanking |
| frame_start | output | 1 | One-cycle pulse when a new frame begins |
| latch_stb | output | 1 | One-cycle pulse when shadow settings go live |

## Verification
line_num and vblank change on the clock edge that samples line_stb. frame_start and latch_stb are high for exactly the clock that follows that edge. The bench raises line_stb for one clock from a falling edge and reads every output at the next falling edge, so each pulse is caught in the single cycle in which it is valid. A push or setting write is issued in full before the strobe of the line that should react to it. Settings changes always get one unmeasured frame to reach the live copy before any frame length that depends on them is checked.

// File: rtl/vrr_tg_pkg.sv
package vrr_tg_pkg;
  localparam int LINE_W = 12;
  localparam int ADDR_W = 3;
  localparam int PF_W   = 8;
  localparam int FSD_W  = 2;
  localparam int CB_VRR = 0;
  localparam int CB_FLIP = 1;
  localparam int CB_OVR = 2;
  localparam int CB_FSD = 3;
  localparam int CB_PF  = CB_FSD + FSD_W;
  localparam int CFG_DW = CB_PF + PF_W;

  typedef enum logic [ADDR_W-1:0] {
    A_VACT = 3'd0, A_VTOT = 3'd1, A_VMIN = 3'd2, A_VMAX = 3'd3,
    A_FLIP = 3'd4, A_CTRL = 3'd5, A_PUSH = 3'd6
  } cfg_addr_e;

  typedef struct packed {
    logic [LINE_W-1:0] vact;
    logic [LINE_W-1:0] vtot;
    logic [LINE_W-1:0] vmin;
    logic [LINE_W-1:0] vmax;
    logic [LINE_W-1:0] flip;
    logic              vrr_en;
    logic              flip_en;
    logic              pf_ovr;
    logic [PF_W-1:0]   pf;
    logic [FSD_W-1:0]  fsd;
  } tcfg_t;

  typedef enum logic [1:0] {PH_ACTIVE, PH_HOLD, PH_EXIT} vphase_e;
endpackage

// File: rtl/vrr_tg_cfg.sv
module vrr_tg_cfg
  import vrr_tg_pkg::*;
#(
  parameter int DEF_VACT = 8,
  parameter int DEF_VTOT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CFG_DW-1:0] wr_data,
  input  logic              latch_en,
  output tcfg_t             live_cfg
);
  localparam tcfg_t RST_CFG = '{
    vact: LINE_W'(DEF_VACT), vtot: LINE_W'(DEF_VTOT - 1),
    vmin: LINE_W'(DEF_VTOT - 1), vmax: LINE_W'(DEF_VTOT - 1),
    flip: LINE_W'(DEF_VTOT), vrr_en: 1'b0, flip_en: 1'b0, pf_ovr: 1'b0,
    pf: '0, fsd: '0};

  tcfg_t shadow_q, shadow_d, live_q;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) begin
      case (cfg_addr_e'(wr_addr))
        A_VACT: shadow_d.vact = wr_data[LINE_W-1:0];
        A_VTOT: shadow_d.vtot = wr_data[LINE_W-1:0];
        A_VMIN: shadow_d.vmin = wr_data[LINE_W-1:0];
        A_VMAX: shadow_d.vmax = wr_data[LINE_W-1:0];
        A_FLIP: shadow_d.flip = wr_data[LINE_W-1:0];
        A_CTRL: begin
          shadow_d.vrr_en  = wr_data[CB_VRR];
          shadow_d.flip_en = wr_data[CB_FLIP];
          shadow_d.pf_ovr  = wr_data[CB_OVR];
          shadow_d.fsd     = wr_data[CB_FSD +: FSD_W];
          shadow_d.pf      = wr_data[CB_PF +: PF_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RST_CFG;
      live_q   <= RST_CFG;
    end else begin
      shadow_q <= shadow_d;
      if (latch_en) live_q <= shadow_q;
    end
  end

  assign live_cfg = live_q;

  // R5: the live copy moves only on a latch
  assert_live_only_on_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch_en) |-> $stable(live_q));
endmodule

// File: rtl/vrr_tg_push.sv
module vrr_tg_push
  import vrr_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        req_bits,
  input  logic              vrr_on,
  input  logic              exit_go,
  output logic              pend
);
  logic pend_q, pend_d, push_wr;

  assign push_wr = wr_en && (cfg_addr_e'(wr_addr) == A_PUSH);

  always_comb begin
    pend_d = pend_q;
    if (exit_go) pend_d = 1'b0;
    if (push_wr) begin
      if (!req_bits[0])     pend_d = 1'b0;
      else if (req_bits[1]) pend_d = 1'b1;
    end
    if (!vrr_on) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R11: a request appears only from an enable+send write in variable mode
  assert_push_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(push_wr && req_bits == 2'b11 && vrr_on));
  // R11: a request is dropped only by an exit, a push write or leaving variable mode
  assert_push_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(exit_go || push_wr || !vrr_on));
endmodule

// File: rtl/vrr_tg_seq.sv
module vrr_tg_seq
  import vrr_tg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  tcfg_t             cfg,
  input  logic              push_pend,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              frame_start,
  output logic              latch_stb,
  output logic              latch_now,
  output logic              exit_go
);
  localparam int W2 = LINE_W + 2;

  logic [LINE_W-1:0] line_q, line_d;
  logic [W2-1:0]     end_q, end_d;
  vphase_e           ph_q, ph_d;
  logic              fs_q, fs_d, lat_q, lat_d, go_d;
  logic [W2-1:0]     exit_len, min_ref, min_raw, min_pt, max_pt;
  logic [W2-1:0]     nxt_line, vact_x, vtot_x, vmax_x;

  // line arithmetic for the decision points
  always_comb begin
    exit_len = W2'(cfg.fsd) + W2'(1) + (cfg.pf_ovr ? W2'(cfg.pf) : '0);
    min_ref  = cfg.flip_en ? W2'(cfg.flip) + W2'(1) : W2'(cfg.vmin) + W2'(2);
    min_raw  = (min_ref > exit_len) ? min_ref - exit_len : '0;
    vact_x   = W2'(cfg.vact);
    min_pt   = (min_raw > vact_x) ? min_raw : vact_x + W2'(1);
    vmax_x   = W2'(cfg.vmax) + W2'(1);
    max_pt   = (vmax_x > exit_len) ? vmax_x - exit_len : '0;
    vtot_x   = W2'(cfg.vtot) + W2'(1);
    nxt_line = W2'(line_q) + W2'(1);
  end

  // next state
  always_comb begin
    ph_d   = ph_q;
    line_d = line_q;
    end_d  = end_q;
    fs_d   = 1'b0;
    lat_d  = 1'b0;
    go_d   = 1'b0;
    if (line_stb) begin
      line_d = nxt_line[LINE_W-1:0];
      case (ph_q)
        PH_ACTIVE: begin
          if (nxt_line == vact_x) begin
            ph_d  = PH_HOLD;
            lat_d = !cfg.vrr_en;
          end
        end
        PH_HOLD: begin
          if (!cfg.vrr_en) begin
            if (nxt_line >= vtot_x) begin
              line_d = '0;
              ph_d   = PH_ACTIVE;
              fs_d   = 1'b1;
            end
          end else if (nxt_line >= min_pt && (push_pend || nxt_line >= max_pt)) begin
            ph_d  = PH_EXIT;
            end_d = nxt_line + exit_len;
            lat_d = 1'b1;
            go_d  = 1'b1;
          end
        end
        PH_EXIT: begin
          if (nxt_line >= end_q) begin
            line_d = '0;
            ph_d   = PH_ACTIVE;
            fs_d   = 1'b1;
          end
        end
        default: ph_d = PH_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      end_q  <= '0;
      ph_q   <= PH_ACTIVE;
      fs_q   <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      if (line_stb) begin
        line_q <= line_d;
        end_q  <= end_d;
        ph_q   <= ph_d;
      end
      fs_q  <= fs_d;
      lat_q <= lat_d;
    end
  end

  assign line_num    = line_q;
  assign vblank      = (ph_q != PH_ACTIVE);
  assign frame_start = fs_q;
  assign latch_stb   = lat_q;
  assign latch_now   = lat_d;
  assign exit_go     = go_d;

  // R2: the line count holds without a strobe
  assert_line_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(line_stb) |-> $stable(line_num));
  // R2: blanking ends only at a frame wrap
  assert_vblank_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> frame_start);
  // R3: frame start lands on line zero right after a strobe
  assert_frame_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_num == '0) && $past(line_stb));
  // R4: latch strobe follows a line strobe and lies inside blanking
  assert_latch_in_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> $past(line_stb) && vblank);
endmodule

// File: rtl/vrr_vtiming_gen.sv
module vrr_vtiming_gen
  import vrr_tg_pkg::*;
#(
  parameter int DEF_VACT = 8,
  parameter int DEF_VTOT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [LINE_W-1:0] line_num,
  output logic              vblank,
  output logic              frame_start,
  output logic              latch_stb
);
  tcfg_t live_cfg;
  logic  latch_now, exit_go, push_pend;

  vrr_tg_cfg #(.DEF_VACT(DEF_VACT), .DEF_VTOT(DEF_VTOT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .latch_en(latch_now), .live_cfg(live_cfg));

  vrr_tg_push u_push (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .req_bits(cfg_wdata[1:0]), .vrr_on(live_cfg.vrr_en),
    .exit_go(exit_go), .pend(push_pend));

  vrr_tg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cfg(live_cfg),
    .push_pend(push_pend), .line_num(line_num), .vblank(vblank),
    .frame_start(frame_start), .latch_stb(latch_stb),
    .latch_now(latch_now), .exit_go(exit_go));
endmodule

// File: tb/test_vrr_vtiming_gen.sv
module test_vrr_vtiming_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_stb;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [12:0] cfg_wdata;
  logic [11:0] line_num;
  logic        vblank, frame_start, latch_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  vrr_vtiming_gen i_vrr_vtiming_gen (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .line_num(line_num),
    .vblank(vblank), .frame_start(frame_start), .latch_stb(latch_stb));

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 3'(a); cfg_wdata = 13'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    line_stb = 1'b1;
    @(negedge clk);
    line_stb = 1'b0;
  endtask

  // runs to the next frame start; optional push write while at push_line
  task automatic run_frame(input int push_line, input int push_val,
                           output int len, output int lat_ln, output int vb_ln);
    len = 0; lat_ln = -1; vb_ln = -1;
    for (int k = 0; k < 200; k++) begin
      if (int'(line_num) == push_line) wr_reg(6, push_val);
      step();
      len++;
      if (latch_stb && lat_ln < 0) lat_ln = int'(line_num);
      if (vblank && vb_ln < 0) vb_ln = int'(line_num);
      if (frame_start) break;
    end
  endtask

  task automatic t_reset();
    chk("R1", "line_num", int'(line_num), 0);
    chk("R1", "vblank", int'(vblank), 0);
    chk("R1", "frame_start", int'(frame_start), 0);
    chk("R1", "latch_stb", int'(latch_stb), 0);
  endtask

  task automatic t_fixed();
    int len, lat, vb;
    step();
    chk("R2", "line after one strobe", int'(line_num), 1);
    repeat (10) @(negedge clk);
    chk("R2", "line held without strobe", int'(line_num), 1);
    run_frame(-1, 0, len, lat, vb);
    chk("R3", "fixed frame remainder", len, 11);
    chk("R4", "fixed latch line", lat, 8);
    chk("R2", "vblank start line", vb, 8);
    chk("R3", "line after wrap", int'(line_num), 0);
    @(negedge clk);
    chk("R3", "frame_start one cycle", int'(frame_start), 0);
    run_frame(-1, 0, len, lat, vb);
    chk("R1", "default frame length", len, 12);
  endtask

  task automatic t_dbuf();
    int len, lat, vb;
    step(); step();
    wr_reg(1, 15);
    run_frame(-1, 0, len, lat, vb);
    chk("R5", "write before latch applies", len, 14);
    repeat (10) step();
    wr_reg(1, 11);
    run_frame(-1, 0, len, lat, vb);
    chk("R5", "write after latch deferred", len, 6);
    run_frame(-1, 0, len, lat, vb);
    chk("R5", "deferred write applies next", len, 12);
  endtask

  task automatic t_vrr();
    int len, lat, vb;
    wr_reg(2, 11); wr_reg(3, 19); wr_reg(4, 12);
    wr_reg(5, 1 | 2 | 4 | (1 << 3) | (2 << 5));
    run_frame(-1, 0, len, lat, vb);
    run_frame(-1, 0, len, lat, vb);
    chk("R8", "no-push frame length", len, 20);
    chk("R7", "no-push exit/latch line", lat, 16);
    chk("R6", "vblank line in variable mode", vb, 8);
    run_frame(2, 3, len, lat, vb);
    chk("R9", "early push frame length", len, 13);
    chk("R9", "early push latch line", lat, 9);
    run_frame(12, 3, len, lat, vb);
    chk("R10", "late push frame length", len, 17);
    chk("R10", "late push latch line", lat, 13);
    run_frame(2, 3, len, lat, vb);
    chk("R11", "single push short frame", len, 13);
    run_frame(-1, 0, len, lat, vb);
    chk("R11", "push consumed once", len, 20);
    run_frame(2, 2, len, lat, vb);
    chk("R11", "send without enable ignored", len, 20);
  endtask

  task automatic t_no_ovr();
    int len, lat, vb;
    wr_reg(5, 1 | 2 | (1 << 3) | (2 << 5));
    run_frame(-1, 0, len, lat, vb);
    run_frame(-1, 0, len, lat, vb);
    chk("R7", "no override frame length", len, 20);
    chk("R7", "no override exit line", lat, 18);
    run_frame(2, 3, len, lat, vb);
    chk("R7", "no override early push length", len, 13);
    chk("R9", "no override min point", lat, 11);
  endtask

  task automatic t_flip();
    int len, lat, vb;
    wr_reg(4, 14);
    run_frame(-1, 0, len, lat, vb);
    run_frame(2, 3, len, lat, vb);
    chk("R9", "flip line on min length", len, 15);
    wr_reg(5, 1 | (1 << 3) | (2 << 5));
    run_frame(-1, 0, len, lat, vb);
    run_frame(2, 3, len, lat, vb);
    chk("R9", "flip line off uses vmin", len, 13);
  endtask

  task automatic t_disable();
    int len, lat, vb;
    wr_reg(5, 0);
    wr_reg(6, 0);
    run_frame(-1, 0, len, lat, vb);
    run_frame(2, 3, len, lat, vb);
    chk("R12", "fixed length after disable", len, 12);
    chk("R12", "fixed latch after disable", lat, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; line_stb = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_dbuf();
    t_vrr();
    t_no_ovr();
    t_flip();
    t_disable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule